// File: doc/BRIEF.md
# Clock Synthesizer Serial Loader

This block programs an external frequency synthesizer through three single-wire outputs: a serial data line, a serial clock and a generator-select strobe. A host places a 7-bit N divider, a 7-bit M divider, a 1-bit V control, a 2-bit X control and a 2-bit R control on the inputs. It also places an optional half-period length on the inputs, then pulses `start_i` for one clock.

The loader begins each transaction with a select preamble. It raises select while data and serial clock sit low, then drops select. After the preamble it shifts out a fixed 24-bit frame. Each field goes out least significant bit first, in the order N, M, V, X, R, and a constant 5-bit trailer of 0x17 follows.

Each bit has a low serial-clock phase, during which data is set up, and a high phase. The synthesizer samples data on the rising serial-clock edge. All three pins carry output enables and are driven only while a transaction is running. A one-cycle done pulse marks the end of a transaction.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, the three output enables and the three pin values are all 0.
- R2: `start_i` high while idle is accepted at that clock edge. For the next P cycles, `busy_o` and the three enables are 1, `gsel_o` is 1, and `sdata_o` and `sclk_o` are 0.
- R3: For the P cycles after the R2 window, `gsel_o`, `sdata_o` and `sclk_o` are all 0 while the pins are still enabled.
- R4: The frame word is W = N + M·2^7 + V·2^14 + X·2^15 + R·2^17 + 0x17·2^19. Its bits go out in index order 0 to 23, so each field is sent LSB first and the trailer 0x17 comes last.
- R5: Each frame bit k takes 2P cycles. In the first P cycles `sclk_o` is 0 and `sdata_o` is W[k]. In the next P cycles `sclk_o` is 1 and `sdata_o` still holds W[k], so data changes only while `sclk_o` is low.
- R6: P is the value on `phase_cycles_i` at the accepting edge. A value of 0 selects the default half-period `DEF_PHASE` (4).
- R7: `busy_o` stays high for exactly 50·P cycles. In the following cycle the enables and `busy_o` are 0 and `done_o` is 1. `done_o` lasts one cycle.
- R8: A start pulse, or a change of fields or `phase_cycles_i`, while busy has no effect on the frame or timing in progress, and no second transaction follows.
- R9: Whenever the pins are released, `sdata_o`, `sclk_o` and `gsel_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| n_i | input | 7 | N divider field |
| m_i | input | 7 | M divider field |
| v_i | input | 1 | V control field |
| x_i | input | 2 | X control field |
| r_i | input | 2 | R control field |
| phase_cycles_i | input | PHASE_W | Half-bit length in clocks, 0 selects default |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sdata_o | output | 1 | Serial data value |
| sdata_oe_o | output | 1 | Serial data output enable |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe_o | output | 1 | Serial clock output enable |
| gsel_o | output | 1 | Generator select value |
| gsel_oe_o | output | 1 | Generator select output enable |

## Verification
The assertions assume that reset is held low for at least one clock before the first start. They place no other condition on the inputs: start pulses and field changes during a transaction are legal and must be ignored.

The stimulus keeps `phase_cycles_i` within its declared width and sweeps it across its whole range, including 0. It walks a single one across every field bit and drives all-ones and all-zeros patterns. During some transactions it deliberately pulses start with different fields and a different phase length, so the capture-and-hold behaviour the assertions rely on is exercised rather than merely assumed.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int N_W       = 7;
  localparam int M_W       = 7;
  localparam int V_W       = 1;
  localparam int X_W       = 2;
  localparam int R_W       = 2;
  localparam int TAIL_W    = 5;
  localparam logic [TAIL_W-1:0] TAIL_CODE = 5'h17;
  localparam int FRAME_W   = N_W + M_W + V_W + X_W + R_W + TAIL_W;
  localparam int IDX_W     = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEL_HI = 3'd1,
    ST_SEL_LO = 3'd2,
    ST_CLK_LO = 3'd3,
    ST_CLK_HI = 3'd4
  } xfer_state_t;

  // Frame word: bit 0 is shifted first, so concatenation keeps each field LSB first.
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [N_W-1:0] n,
    input logic [M_W-1:0] m,
    input logic [V_W-1:0] v,
    input logic [X_W-1:0] x,
    input logic [R_W-1:0] r
  );
    return {TAIL_CODE, r, x, v, m, n};
  endfunction

  // Half-period in effect: a zero request falls back to the default.
  function automatic int unsigned eff_phase(input int unsigned req, input int unsigned dflt);
    return (req == 0) ? dflt : req;
  endfunction

endpackage

// File: rtl/syn_phase_timer.sv
module syn_phase_timer #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] len_i,
  output logic               tick_o
);

  logic [PHASE_W-1:0] cnt_q;

  // Tick on the last clock of each phase; len_i is never zero here.
  assign tick_o = run_i && (cnt_q == len_i - PHASE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || tick_o || !run_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PHASE_W'(1);
    end
  end

endmodule

// File: rtl/syn_frame_store.sv
module syn_frame_store
  import synth_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [N_W-1:0]     n_i,
  input  logic [M_W-1:0]     m_i,
  input  logic [V_W-1:0]     v_i,
  input  logic [X_W-1:0]     x_i,
  input  logic [R_W-1:0]     r_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               bit_o,
  output logic [FRAME_W-1:0] word_o
);

  logic [FRAME_W-1:0] word_q;
  logic [FRAME_W-1:0] sel_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= pack_frame(n_i, m_i, v_i, x_i, r_i);
    end
  end

  // One-hot select per frame position, then OR-reduce.
  for (genvar g = 0; g < FRAME_W; g++) begin : g_pick
    assign sel_vec[g] = word_q[g] && (idx_i == IDX_W'(g));
  end

  assign bit_o  = |sel_vec;
  assign word_o = word_q;

endmodule

// File: rtl/syn_xfer_fsm.sv
module syn_xfer_fsm
  import synth_cfg_pkg::*;
#(
  parameter int PHASE_W   = 4,
  parameter int DEF_PHASE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_cycles_i,
  input  logic               tick_i,
  output logic               accept_o,
  output logic               active_o,
  output logic [PHASE_W-1:0] len_o,
  output xfer_state_t        state_o,
  output logic [IDX_W-1:0]   bit_idx_o,
  output logic               done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  xfer_state_t        state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [PHASE_W-1:0] len_q;
  logic               done_q;
  logic               last_edge;

  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign active_o  = (state_q != ST_IDLE);
  assign last_edge = tick_i && (state_q == ST_CLK_HI) && (idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SEL_HI;
          idx_d   = '0;
        end
      end
      ST_SEL_HI: if (tick_i) state_d = ST_SEL_LO;
      ST_SEL_LO: if (tick_i) state_d = ST_CLK_LO;
      ST_CLK_LO: if (tick_i) state_d = ST_CLK_HI;
      ST_CLK_HI: begin
        if (tick_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_CLK_LO;
            idx_d   = idx_q + IDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= PHASE_W'(DEF_PHASE);
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= last_edge;
      if (accept_o) begin
        len_q <= PHASE_W'(eff_phase(int'(phase_cycles_i), DEF_PHASE));
      end
    end
  end

  assign len_o     = len_q;
  assign state_o   = state_q;
  assign bit_idx_o = idx_q;
  assign done_o    = done_q;

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int PHASE_W   = 4,
  parameter int DEF_PHASE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [6:0]         n_i,
  input  logic [6:0]         m_i,
  input  logic               v_i,
  input  logic [1:0]         x_i,
  input  logic [1:0]         r_i,
  input  logic [PHASE_W-1:0] phase_cycles_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               sdata_o,
  output logic               sdata_oe_o,
  output logic               sclk_o,
  output logic               sclk_oe_o,
  output logic               gsel_o,
  output logic               gsel_oe_o
);

  localparam int PIN_CNT = 3;

  // Named internal events, observed by the bound checker.
  logic               accept;
  logic               active;
  logic               phase_tick;
  logic [PHASE_W-1:0] phase_len;
  xfer_state_t        xfer_state;
  logic [IDX_W-1:0]   bit_index;
  logic               frame_bit;
  logic [FRAME_W-1:0] frame_word;
  logic [PIN_CNT-1:0] pin_val;
  logic [PIN_CNT-1:0] pin_oe;

  syn_phase_timer #(.PHASE_W(PHASE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept),
    .run_i   (active),
    .len_i   (phase_len),
    .tick_o  (phase_tick)
  );

  syn_frame_store u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .n_i    (n_i),
    .m_i    (m_i),
    .v_i    (v_i),
    .x_i    (x_i),
    .r_i    (r_i),
    .idx_i  (bit_index),
    .bit_o  (frame_bit),
    .word_o (frame_word)
  );

  syn_xfer_fsm #(.PHASE_W(PHASE_W), .DEF_PHASE(DEF_PHASE)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .phase_cycles_i (phase_cycles_i),
    .tick_i         (phase_tick),
    .accept_o       (accept),
    .active_o       (active),
    .len_o          (phase_len),
    .state_o        (xfer_state),
    .bit_idx_o      (bit_index),
    .done_o         (done_o)
  );

  // Pin order inside the vectors: 0 data, 1 serial clock, 2 select.
  assign pin_val[0] = ((xfer_state == ST_CLK_LO) || (xfer_state == ST_CLK_HI)) && frame_bit;
  assign pin_val[1] = (xfer_state == ST_CLK_HI);
  assign pin_val[2] = (xfer_state == ST_SEL_HI);

  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin_oe
    assign pin_oe[p] = active;
  end

  assign busy_o     = active;
  assign sdata_o    = pin_val[0];
  assign sclk_o     = pin_val[1];
  assign gsel_o     = pin_val[2];
  assign sdata_oe_o = pin_oe[0];
  assign sclk_oe_o  = pin_oe[1];
  assign gsel_oe_o  = pin_oe[2];

endmodule

// File: rtl/synth_cfg_checker.sv
module synth_cfg_checker
  import synth_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               busy_o,
  input logic               done_o,
  input logic               sdata_o,
  input logic               sdata_oe_o,
  input logic               sclk_o,
  input logic               sclk_oe_o,
  input logic               gsel_o,
  input logic               gsel_oe_o,
  input logic [FRAME_W-1:0] frame_word,
  input logic [IDX_W-1:0]   bit_index
);

  assert_enables_follow_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe_o == busy_o) && (sclk_oe_o == busy_o) && (gsel_oe_o == busy_o));

  assert_released_pins_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sdata_o && !sclk_o && !gsel_o));

  assert_preamble_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (gsel_o && !sclk_o && !sdata_o));

  assert_select_quiet_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gsel_o |-> (!sclk_o && !sdata_o));

  assert_data_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$stable(sdata_o)) |-> !sclk_o);

  assert_data_held_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdata_o));

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_frame_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(frame_word));

  assert_index_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_index < IDX_W'(FRAME_W));

endmodule

bind synth_cfg_loader synth_cfg_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .sclk_o     (sclk_o),
  .sclk_oe_o  (sclk_oe_o),
  .gsel_o     (gsel_o),
  .gsel_oe_o  (gsel_oe_o),
  .frame_word (frame_word),
  .bit_index  (bit_index)
);

// File: tb/test_synth_cfg_loader.sv
`timescale 1ns/1ps
module test_synth_cfg_loader;

  localparam int PW   = 4;
  localparam int DEFP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [6:0]    n_i = '0;
  logic [6:0]    m_i = '0;
  logic          v_i = 1'b0;
  logic [1:0]    x_i = '0;
  logic [1:0]    r_i = '0;
  logic [PW-1:0] phase_cycles_i = '0;
  logic busy_o, done_o, sdata_o, sdata_oe_o, sclk_o, sclk_oe_o, gsel_o, gsel_oe_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  synth_cfg_loader #(.PHASE_W(PW), .DEF_PHASE(DEFP)) i_synth_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .n_i(n_i), .m_i(m_i), .v_i(v_i), .x_i(x_i), .r_i(r_i),
    .phase_cycles_i(phase_cycles_i),
    .busy_o(busy_o), .done_o(done_o),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .gsel_o(gsel_o), .gsel_oe_o(gsel_oe_o)
  );

  // Observed pins packed as {busy, done, oe_d, oe_c, oe_s, data, sclk, sel}.
  function automatic logic [7:0] observe();
    return {busy_o, done_o, sdata_oe_o, sclk_oe_o, gsel_oe_o, sdata_o, sclk_o, gsel_o};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cycles, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // Runs one transaction; 'poke' pulses start with other values mid-flight (R8).
  task automatic run_xfer(input logic [18:0] fields, input int ph_req, input bit poke);
    int p;
    longint word;
    logic [23:0] rx;
    int rxn;
    logic prev_sclk;
    logic [7:0] exp;
    string req;
    p = (ph_req == 0) ? DEFP : ph_req;                     // R6
    word = longint'(fields[6:0]) + longint'(fields[13:7]) * 128
         + longint'(fields[14]) * 16384 + longint'(fields[16:15]) * 32768
         + longint'(fields[18:17]) * 131072 + 23 * 524288;  // R4
    n_i = fields[6:0]; m_i = fields[13:7]; v_i = fields[14];
    x_i = fields[16:15]; r_i = fields[18:17];
    phase_cycles_i = PW'(ph_req);
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    rx = '0; rxn = 0; prev_sclk = 1'b0;
    for (int c = 0; c < 50 * p; c++) begin
      int ph;
      int b;
      ph = c / p;
      if (ph == 0) begin
        exp = 8'b1_0_111_0_0_1; req = "R2";
      end else if (ph == 1) begin
        exp = 8'b1_0_111_0_0_0; req = "R3";
      end else begin
        b = (ph - 2) / 2;
        exp = {5'b1_0_111, word[b] ? 1'b1 : 1'b0, ((ph - 2) % 2 == 1), 1'b0};
        req = "R5";
      end
      check(req, observe(), exp);
      if (sclk_o && !prev_sclk && rxn < 24) begin
        rx[rxn] = sdata_o;
        rxn++;
      end
      prev_sclk = sclk_o;
      if (poke && c == 3) begin
        start_i = 1'b1; n_i = ~n_i; m_i = ~m_i; r_i = ~r_i;
        phase_cycles_i = PW'(p == 1 ? 2 : 1);
      end else if (poke && c == 4) begin
        start_i = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    check("R4", {rx[23:16], 8'h00}, {8'(word >> 16), 8'h00});
    check("R4", rx[15:8], 8'(word >> 8));
    check("R4", rx[7:0], 8'(word));
    check("R7", observe(), 8'b0_1_000_0_0_0);
    @(posedge clk); @(negedge clk);
    check(poke ? "R8" : "R9", observe(), 8'b0_0_000_0_0_0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", observe(), 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", observe(), 8'h00);
    repeat (2) @(negedge clk);
    check("R1", observe(), 8'h00);

    // R6: sweep the whole half-period range, including the zero default.
    for (int ph = 0; ph < (1 << PW); ph++) begin
      run_xfer(19'h5A3C6, ph, ph[0]);
    end
    // R4: walking one across every field bit, shortest period.
    for (int j = 0; j < 19; j++) begin
      run_xfer(19'(1) << j, 1, (j % 3) == 0);
    end
    run_xfer('1, 3, 1'b1);
    run_xfer('0, 2, 1'b0);
    run_xfer(19'h2AAAA, 0, 1'b1);

    // R8: idle gaps show no queued transaction.
    repeat (5) begin
      @(negedge clk);
      check("R8", observe(), 8'h00);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule